// File: doc/BRIEF.md
# Staged Walsh-Hadamard Transform Engine

This block takes a frame of 128 signed 8-bit in-phase samples and turns it into its Walsh-Hadamard spectrum. It uses only adders and subtractors, with no multipliers. A start pulse copies the whole input frame into a private working bank. A small controller then applies seven butterfly passes to that bank, one pass per clock. Pass s pairs entries that lie 2^s apart. Each pair (x, y) becomes the pair of halved values floor((x+y)/2) and floor((x−y)/2). Because of the halving, every word stays 8 bits wide, and the finished spectrum is the unnormalised transform scaled by 1/128.

The host drives the frame in parallel and pulses start. It then waits for the done flag, which stays high until the next accepted start, and reads all 128 results from a parallel bus. The controller has three states. IDLE waits after reset. RUN steps through the passes with a pass counter. DONE holds the results. Its transitions are:
- IDLE→RUN on start, which is the copy edge.
- RUN→RUN while the pass counter is below six.
- RUN→DONE when the last pass is applied.
- DONE→RUN on a new start.

Top module: `wht128_engine`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and every result word is 0.
- R2: The frame is captured only on the clock edge that accepts start. Changes on frame_i after that edge do not affect the results.
- R3: The results equal the pass sequence with spans 1, 2, 4, 8, 16, 32, 64, in that order. Each pass replaces entry j and entry j+h (j with bit h clear) by floor((x+y)/2) and floor((x−y)/2).
- R4: done_o rises exactly 7 clock edges after the edge that accepts start.
- R5: A start pulse while a transform is running (state RUN) is ignored. The running transform keeps its frame and its timing.
- R6: done_o stays 1 until the next start. A start while done is accepted, and done_o is 0 after that edge.
- R7: Full-scale frames do not overflow. An all −128 frame gives −128 in word 0 and 0 elsewhere. An all 127 frame gives 127 in word 0 and 0 elsewhere.
- R8: While done_o is 1 and no start arrives, result_o does not change.
- R9: Sample k sits at frame_i[8k+7:8k], and result word k sits at result_o[8k+7:8k], both two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted in IDLE or DONE |
| frame_i | input | 1024 | 128 signed 8-bit samples, sample k at bits 8k+7:8k |
| done_o | output | 1 | Results valid; held until the next accepted start |
| result_o | output | 1024 | 128 signed 8-bit results, word k at bits 8k+7:8k |

## Verification
The bench builds the engine with its default sizes: seven passes over 128 words of 8 bits. At these sizes the full-scale extremes of both signs are within reach, which exercises the floor rounding of the halved difference and the no-overflow claim at both rails. The default pass count also makes the seven-edge latency, a start landing mid-run, and a restart from DONE observable with the real counter width.

// File: rtl/wht_pkg.sv
package wht_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } wht_state_e;
endpackage

// File: rtl/wht_span_stage.sv
// One butterfly pass over the whole bank for a fixed span.
// floor((a+b)/2) and floor((a-b)/2) are formed from halved operands plus a
// low-bit correction, which equals the 9-bit sum shifted right by one.
module wht_span_stage #(
    parameter int N    = 128,
    parameter int W    = 8,
    parameter int SPAN = 1
) (
    input  logic [N*W-1:0] vec_i,
    output logic [N*W-1:0] vec_o
);
    localparam logic [W-1:0] ONE = W'(1);

    for (genvar p = 0; p < N; p++) begin : g_word
        if ((p & SPAN) == 0) begin : g_pair
            localparam int Q = p + SPAN;
            logic signed [W-1:0] a, b, ah, bh;
            logic                sum_fix, dif_fix;
            assign a       = vec_i[p*W +: W];
            assign b       = vec_i[Q*W +: W];
            assign ah      = a >>> 1;
            assign bh      = b >>> 1;
            assign sum_fix = a[0] & b[0];
            assign dif_fix = ~a[0] & b[0];
            assign vec_o[p*W +: W] = ah + bh + (sum_fix ? ONE : '0);
            assign vec_o[Q*W +: W] = ah - bh - (dif_fix ? ONE : '0);
        end
    end
endmodule

// File: rtl/wht_stage_net.sv
// All passes built in parallel; the pass counter picks which one feeds the bank.
module wht_stage_net #(
    parameter int N      = 128,
    parameter int W      = 8,
    parameter int STAGES = 7,
    parameter int SW     = 3
) (
    input  logic [SW-1:0]  stage_i,
    input  logic [N*W-1:0] vec_i,
    output logic [N*W-1:0] vec_o
);
    logic [N*W-1:0] pass_out [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_pass
        wht_span_stage #(.N(N), .W(W), .SPAN(1 << s)) u_pass (
            .vec_i(vec_i),
            .vec_o(pass_out[s])
        );
    end

    always_comb begin
        vec_o = pass_out[0];
        for (int s = 1; s < STAGES; s++) begin
            if (stage_i == SW'(s)) vec_o = pass_out[s];
        end
    end
endmodule

// File: rtl/wht_ctrl.sv
module wht_ctrl #(
    parameter int STAGES = 7,
    parameter int SW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          step_o,
    output logic [SW-1:0] stage_o,
    output logic          done_o
);
    import wht_pkg::*;

    localparam logic [SW-1:0] LAST = SW'(STAGES - 1);

    wht_state_e state_q, state_d;
    logic [SW-1:0] stage_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (stage_q == LAST) state_d = ST_DONE;
            ST_DONE: if (start_i) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_o)      stage_q <= '0;
            else if (step_o) stage_q <= stage_q + SW'(1);
        end
    end

    always_comb begin
        load_o  = 1'b0;
        step_o  = 1'b0;
        done_o  = 1'b0;
        stage_o = stage_q;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN:  step_o = 1'b1;
            ST_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wht_bank.sv
module wht_bank #(
    parameter int NW = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [NW-1:0] frame_i,
    input  logic [NW-1:0] pass_i,
    output logic [NW-1:0] bank_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bank_o <= '0;
        else if (load_i) bank_o <= frame_i;
        else if (step_i) bank_o <= pass_i;
    end
endmodule

// File: rtl/wht128_engine.sv
module wht128_engine #(
    parameter int LOG2N = 7,
    parameter int W     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [(1<<LOG2N)*W-1:0] frame_i,
    output logic                   done_o,
    output logic [(1<<LOG2N)*W-1:0] result_o
);
    localparam int N      = 1 << LOG2N;
    localparam int NW     = N * W;
    localparam int STAGES = LOG2N;
    localparam int SW     = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic          load, step;
    logic [SW-1:0] stage;
    logic [NW-1:0] pass_vec;

    wht_ctrl #(.STAGES(STAGES), .SW(SW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .step_o(step), .stage_o(stage), .done_o(done_o)
    );

    wht_stage_net #(.N(N), .W(W), .STAGES(STAGES), .SW(SW)) u_net (
        .stage_i(stage), .vec_i(result_o), .vec_o(pass_vec)
    );

    wht_bank #(.NW(NW)) u_bank (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .frame_i(frame_i), .pass_i(pass_vec), .bank_o(result_o)
    );
endmodule

// File: rtl/wht_engine_chk.sv
module wht_engine_chk #(
    parameter int LOG2N = 7,
    parameter int W     = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    done_o,
    input logic [(1<<LOG2N)*W-1:0] result_o
);
    localparam int STAGES = LOG2N;

    logic        busy_q;
    logic [31:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 32'd1;
            if (cnt_q == 32'(STAGES)) busy_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= 32'd1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!done_o && result_o == '0);
        end
    end

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == 32'(STAGES)) |=> $rose(done_o));

    // R5
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q < 32'(STAGES)) |=> !done_o);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R6
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o);

    // R8
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(result_o));
endmodule

bind wht128_engine wht_engine_chk #(.LOG2N(LOG2N), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .done_o(done_o), .result_o(result_o)
);

// File: tb/tb_wht128_engine.sv
`timescale 1ns/1ps
module tb_wht128_engine;
    localparam int LOG2N = 7;
    localparam int W     = 8;
    localparam int N     = 1 << LOG2N;
    localparam int NW    = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NW-1:0] frame_i = '0;
    logic          done_o;
    logic [NW-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wht128_engine #(.LOG2N(LOG2N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .frame_i(frame_i), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [NW-1:0] model(input logic [NW-1:0] f);
        int a [N];
        logic [NW-1:0] r;
        for (int k = 0; k < N; k++) a[k] = int'($signed(f[k*W +: W]));
        for (int h = 1; h < N; h = h * 2) begin
            for (int i = 0; i < N; i += 2 * h) begin
                for (int j = i; j < i + h; j++) begin
                    int x, y;
                    x = a[j];
                    y = a[j+h];
                    a[j]   = (x + y) >>> 1;
                    a[j+h] = (x - y) >>> 1;
                end
            end
        end
        for (int k = 0; k < N; k++) r[k*W +: W] = a[k][W-1:0];
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [NW-1:0] exp);
        checks++;
        if (result_o !== exp) begin
            errors++;
            for (int k = 0; k < N; k++) begin
                if (result_o[k*W +: W] !== exp[k*W +: W]) begin
                    $display("FAIL %s word %0d actual=%0d expected=%0d", tag, k,
                             $signed(result_o[k*W +: W]), $signed(exp[k*W +: W]));
                    break;
                end
            end
        end
    endtask

    // Pulse start, optionally disturb frame / start mid-run, check R4 timing.
    task automatic run_frame(input logic [NW-1:0] f, input string tag,
                             input bit disturb);
        logic [NW-1:0] exp;
        bit timing_ok;
        exp = model(f);
        timing_ok = 1'b1;
        @(negedge clk);
        frame_i = f;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_bit({tag, " R6 done low after accepted start"}, done_o, 1'b0);
        if (disturb) frame_i = ~f;   // R2: late frame change
        for (int k = 1; k <= 7; k++) begin
            if (disturb && k == 2) start_i = 1'b1;  // R5: start while running
            if (disturb && k == 3) start_i = 1'b0;
            @(negedge clk);
            if (done_o !== (k == 7)) timing_ok = 1'b0;
        end
        check_bit({tag, " R4 done after 7 edges"}, timing_ok, 1'b1);
        check_vec({tag, " R3 result"}, exp);
    endtask

    function automatic logic [NW-1:0] fill(input logic [W-1:0] v);
        logic [NW-1:0] r;
        for (int k = 0; k < N; k++) r[k*W +: W] = v;
        return r;
    endfunction

    initial begin
        logic [NW-1:0] f, held, exp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: during reset
        check_bit("R1 done in reset", done_o, 1'b0);
        check_bit("R1 result zero in reset", result_o == '0, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_bit("R1 done after reset", done_o, 1'b0);
        check_bit("R1 result zero after reset", result_o == '0, 1'b1);

        // R9/R3: impulse at sample 0 -> flat 64>>7-ish pattern, and impulse at 5
        f = '0; f[0 +: W] = 8'sd64;
        run_frame(f, "R9 impulse0", 1'b0);
        f = '0; f[5*W +: W] = 8'h80;
        run_frame(f, "R9 impulse5 neg", 1'b0);

        // R7: full-scale frames
        run_frame(fill(8'h80), "R7 all -128", 1'b0);
        exp = '0; exp[0 +: W] = 8'h80;
        check_vec("R7 all -128 direct", exp);
        run_frame(fill(8'h7F), "R7 all 127", 1'b0);
        exp = '0; exp[0 +: W] = 8'h7F;
        check_vec("R7 all 127 direct", exp);

        // R3: alternating rails
        for (int k = 0; k < N; k++) f[k*W +: W] = k[0] ? 8'h80 : 8'h7F;
        run_frame(f, "R3 alternating", 1'b0);

        // R2 + R5: frame disturbed and extra start mid-run
        for (int k = 0; k < N; k++) f[k*W +: W] = W'($urandom);
        run_frame(f, "R2 R5 disturbed", 1'b1);

        // R6/R8: done holds and results stay
        held = result_o;
        repeat (5) @(negedge clk);
        check_bit("R6 done held", done_o, 1'b1);
        check_bit("R8 result held", result_o == held, 1'b1);

        // R3: random frames, started directly from DONE (R6 restart)
        for (int t = 0; t < 6; t++) begin
            for (int k = 0; k < N; k++) f[k*W +: W] = W'($urandom);
            run_frame(f, "R3 random", 1'b0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule